// File: doc/BRIEF.md
# Zero-Crossing Gated Phase Offset Stage

This block builds the phase word for a downstream angle-to-amplitude stage. A phase accumulator adds a frequency tuning word on every clock. A phase offset is added to the upper half of the accumulator. The offset is taken from one of eight words, and a profile select input picks the word.

In direct-switch mode, when the playback target is phase, an optional gate can hold back a newly selected offset. The held offset is committed only on the clock edge at which the accumulator wraps from full scale to zero. With sine output that instant is an amplitude zero crossing, so a 180-degree BPSK jump causes little amplitude disturbance. With cosine output the same instant is the positive peak. A pending flag shows that a selected offset differs from the applied one and is still waiting for the wrap.

Top module: `zc_phase_gate`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the applied offset, `phase_out` and `pending` to zero.
- R2: The accumulator (ACC_W bits) adds `ftw` on every edge and discards the carry. On each edge, `phase_out` takes the accumulator's upper OFS_W bits plus the applied offset, both as they were before that edge, modulo 2^OFS_W.
- R3: When gating is inactive, the applied offset takes the selected word at the next clock edge.
- R4: Gating is active when `zc_en`, `direct_mode` and `dest_phase` are all 1. While it is active, the applied offset changes only on an edge where the accumulator addition carries out of its MSB, and on that edge it takes the selected word.
- R5: With `direct_mode` = 0, `zc_en` has no effect and offsets apply on the next edge.
- R6: With `dest_phase` = 0, `zc_en` has no effect and offsets apply on the next edge.
- R7: When the selection changes several times between two wraps, only the word selected at the wrap edge is committed.
- R8: After each edge, `pending` is 1 exactly when gating is active and the selected word differs from the applied offset.
- R9: Profile k selects the word at bits [OFS_W*k+OFS_W-1 : OFS_W*k] of `phase_words`. Any subset of the select bits may be toggled, which gives two-level or four-level switching.
- R10: A selection change presented on the same edge as a wrap is committed on that edge, and `pending` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw | input | ACC_W (32) | Frequency tuning word |
| phase_words | input | NPROF*OFS_W (128) | Eight packed phase offset words |
| prof_sel | input | SEL_W (3) | Profile select |
| zc_en | input | 1 | Zero-crossing gate enable |
| direct_mode | input | 1 | Direct-switch mode flag |
| dest_phase | input | 1 | Playback target is phase |
| phase_out | output | OFS_W (16) | Combined phase word |
| pending | output | 1 | Selected offset waiting for a wrap |

## Verification
Two functions can fall in the same cycle: a change of profile selection and an accumulator wrap. The bench provokes this by watching its own model of the accumulator. When the model predicts a carry on the next edge, the bench changes `prof_sel` just before that edge. The result is judged by checking that the new word appears in `phase_out` one cycle after the wrap, and that `pending` never rises. The same model also covers the nearby cases where the change comes one cycle before or after the wrap.

// File: rtl/zcp_pkg.sv
package zcp_pkg;
  localparam int ACC_W_DEF = 32;
  localparam int OFS_W_DEF = 16;
  localparam int NPROF_DEF = 8;
endpackage

// File: rtl/zcp_acc.sv
module zcp_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] ftw,
  output logic [ACC_W-1:0] acc_q,
  output logic             wrap
);
  logic [ACC_W:0] sum;

  always_comb sum = {1'b0, acc_q} + {1'b0, ftw};
  assign wrap = sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= sum[ACC_W-1:0];
  end

  // R2: a carry edge leaves a smaller accumulator value
  a_r2_wrap_small: assert property (@(posedge clk) disable iff (rst)
    wrap |=> acc_q < $past(acc_q));
endmodule

// File: rtl/zcp_gate.sv
module zcp_gate #(
  parameter int OFS_W = 16,
  parameter int NPROF = 8,
  localparam int SEL_W = $clog2(NPROF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPROF*OFS_W-1:0] phase_words,
  input  logic [SEL_W-1:0]   prof_sel,
  input  logic               zc_en,
  input  logic               direct_mode,
  input  logic               dest_phase,
  input  logic               wrap,
  output logic [OFS_W-1:0]   ofs_q,
  output logic               pending_q
);
  logic [OFS_W-1:0] target;
  logic [OFS_W-1:0] ofs_d;
  logic             gated;

  always_comb begin
    target = phase_words[prof_sel*OFS_W +: OFS_W];
    gated  = zc_en & direct_mode & dest_phase;
    ofs_d  = (!gated || wrap) ? target : ofs_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q     <= '0;
      pending_q <= 1'b0;
    end else begin
      ofs_q     <= ofs_d;
      pending_q <= gated && (target != ofs_d);
    end
  end

  // R4: held offset does not move between wraps
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (gated && !wrap) |=> $stable(ofs_q));
  // R3: ungated offset follows the selection one edge later
  a_r3_follow: assert property (@(posedge clk) disable iff (rst)
    !gated |=> ofs_q == $past(target));
  // R8: pending can only be raised while gating was active
  a_r8_only_gated: assert property (@(posedge clk) disable iff (rst)
    pending_q |-> $past(gated));
  // R10: a wrap edge always clears pending
  a_r10_wrap_clears: assert property (@(posedge clk) disable iff (rst)
    (gated && wrap) |=> !pending_q);
endmodule

// File: rtl/zcp_combine.sv
module zcp_combine #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] acc_q,
  input  logic [OFS_W-1:0] ofs_q,
  output logic [OFS_W-1:0] phase_out
);
  logic [OFS_W-1:0] acc_hi;
  assign acc_hi = acc_q[ACC_W-1 -: OFS_W];

  always_ff @(posedge clk) begin
    if (rst) phase_out <= '0;
    else     phase_out <= acc_hi + ofs_q;
  end

  // R1: output is cleared by reset
  a_r1_reset_out: assert property (@(posedge clk)
    rst |=> phase_out == '0);
endmodule

// File: rtl/zc_phase_gate.sv
module zc_phase_gate
  import zcp_pkg::*;
#(
  parameter int ACC_W = ACC_W_DEF,
  parameter int OFS_W = OFS_W_DEF,
  parameter int NPROF = NPROF_DEF,
  localparam int SEL_W = $clog2(NPROF)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ACC_W-1:0]       ftw,
  input  logic [NPROF*OFS_W-1:0] phase_words,
  input  logic [SEL_W-1:0]       prof_sel,
  input  logic                   zc_en,
  input  logic                   direct_mode,
  input  logic                   dest_phase,
  output logic [OFS_W-1:0]       phase_out,
  output logic                   pending
);
  logic [ACC_W-1:0] acc_q;
  logic             wrap;
  logic [OFS_W-1:0] ofs_q;

  zcp_acc #(.ACC_W(ACC_W)) acc_i (
    .clk(clk), .rst(rst), .ftw(ftw), .acc_q(acc_q), .wrap(wrap)
  );

  zcp_gate #(.OFS_W(OFS_W), .NPROF(NPROF)) gate_i (
    .clk(clk), .rst(rst), .phase_words(phase_words), .prof_sel(prof_sel),
    .zc_en(zc_en), .direct_mode(direct_mode), .dest_phase(dest_phase),
    .wrap(wrap), .ofs_q(ofs_q), .pending_q(pending)
  );

  zcp_combine #(.ACC_W(ACC_W), .OFS_W(OFS_W)) comb_i (
    .clk(clk), .rst(rst), .acc_q(acc_q), .ofs_q(ofs_q), .phase_out(phase_out)
  );
endmodule

// File: tb/zc_phase_gate_tb_top.sv
module zc_phase_gate_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  ftw = '0;
  logic [127:0] phase_words;
  logic [2:0]   prof_sel = '0;
  logic         zc_en = 1'b0, direct_mode = 1'b0, dest_phase = 1'b0;
  logic [15:0]  phase_out;
  logic         pending;

  int checks = 0, errors = 0;
  logic [31:0] macc = '0;
  logic [15:0] mofs = '0;
  logic [16:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag = "R2";
  bit          done = 0;
  int          r10_hits = 0;

  always #2.5 clk = ~clk;

  zc_phase_gate dut_i (
    .clk(clk), .rst(rst), .ftw(ftw), .phase_words(phase_words),
    .prof_sel(prof_sel), .zc_en(zc_en), .direct_mode(direct_mode),
    .dest_phase(dest_phase), .phase_out(phase_out), .pending(pending)
  );

  function automatic logic [15:0] word(input logic [2:0] k);
    return phase_words[k*16 +: 16];
  endfunction

  function automatic bit carry_next();
    logic [32:0] s;
    s = {1'b0, macc} + {1'b0, ftw};
    return s[32];
  endfunction

  // driver: model one edge with current inputs, push expectation, advance
  task automatic tick();
    logic [32:0] s;
    logic [15:0] t, nofs, eout;
    logic        g, np;
    s    = {1'b0, macc} + {1'b0, ftw};
    t    = word(prof_sel);
    g    = zc_en & direct_mode & dest_phase;
    eout = macc[31:16] + mofs;
    nofs = (!g || s[32]) ? t : mofs;
    np   = g && (t != nofs);
    exp_q.push_back({eout, np});
    tag_q.push_back(cur_tag);
    macc = s[31:0];
    mofs = nofs;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      logic [16:0] e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if ({phase_out, pending} !== e) begin
        errors++;
        $display("FAIL %s: phase_out=%h pending=%b expected phase_out=%h pending=%b",
                 tg, phase_out, pending, e[16:1], e[0]);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) phase_words[k*16 +: 16] = 16'h1111 * k[15:0] + 16'h0100;
    phase_words[4*16 +: 16] = 16'h8000;
    ftw = 32'h0123_4567;
    repeat (4) @(negedge clk);
    checks++;
    if (phase_out !== 16'h0 || pending !== 1'b0) begin
      errors++;
      $display("FAIL R1: phase_out=%h pending=%b expected 0000 0", phase_out, pending);
    end
    rst = 1'b0;

    cur_tag = "R2"; run(20);
    ftw = 32'hF000_0001; run(10);

    cur_tag = "R3"; ftw = 32'h0345_0000;
    for (int i = 0; i < 8; i++) begin prof_sel = i[2:0]; tick(); end

    cur_tag = "R4"; zc_en = 1; direct_mode = 1; dest_phase = 1;
    ftw = 32'h1000_0000;
    prof_sel = 3'd4; run(3);
    prof_sel = 3'd0; run(40);

    cur_tag = "R7";
    prof_sel = 3'd1; tick(); prof_sel = 3'd2; tick(); prof_sel = 3'd6; run(20);

    cur_tag = "R8"; ftw = 32'h0;
    prof_sel = 3'd3; run(10);
    cur_tag = "R5"; direct_mode = 0; run(3);
    prof_sel = 3'd5; run(3);
    direct_mode = 1; ftw = 32'h2000_0000;
    cur_tag = "R6"; dest_phase = 0; prof_sel = 3'd7; run(3);
    prof_sel = 3'd2; run(3); dest_phase = 1;

    cur_tag = "R9";
    for (int i = 0; i < 12; i++) begin
      prof_sel = (i % 2) ? 3'b010 : 3'b000; run(5);
    end
    for (int i = 0; i < 12; i++) begin
      prof_sel = {i[1], 1'b0, i[0]}; run(5);
    end

    cur_tag = "R10"; ftw = 32'h4000_0000;
    for (int n = 0; n < 6; n++) begin
      for (int g = 0; g < 8 && !carry_next(); g++) tick();
      if (carry_next()) r10_hits++;
      prof_sel = prof_sel ^ 3'b100; tick();
      run(2);
    end
    checks++;
    if (r10_hits != 6) begin
      errors++;
      $display("FAIL R10: coincident wrap cases=%0d expected 6", r10_hits);
    end

    cur_tag = "R3"; zc_en = 0; prof_sel = 3'd1; run(4);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule